// File: doc/BRIEF.md
# VID Change Deglitch Controller

This block sits between the processor's voltage-identification pins and the regulator's reference logic. The raw 7-bit code arrives asynchronously to the clock, so it is first resynchronized. A code change is then held back until the bus has stayed stable for a keep-out interval. This stops the regulator from acting on a false intermediate code while the bits are skewed in transition. Only a settled code is passed on as the accepted code.

Each detected change opens a transient window. While the window is open, the block raises a power-good mask so that the output voltage moving to its new target cannot be reported as a fault. It also raises a request that forces multiphase PWM, whatever the other mode inputs ask for. The window covers the whole keep-out. It then stays open for a fixed number of cycles after the code is accepted. Any later change restarts it. Taking enable low resynchronizes the accepted code directly and closes the window. The keep-out and window lengths are cycle-count parameters. The defaults are 40 and 1000 cycles, which is 400 ns and 10 µs at 100 MHz.

Top module: `vid_deglitch_ctrl`

## Requirements
- R1: While `rst_n` is low, `vid_acc` is 0 and `vid_xient`, `pg_mask` and `force_pwm` are all low.
- R2: The raw bus passes through a two-stage synchronizer and then the accepted-code register. With `en` low, a new raw value appears on `vid_acc` at the third rising edge after it is applied.
- R3: With `en` high, a change appears on `vid_acc` only after the synchronized code has stayed unchanged for `KEEPOUT_CYC` consecutive cycles after the change. This is the (3 + `KEEPOUT_CYC`)th rising edge after the raw change. Before that edge, `vid_acc` keeps its old value.
- R4: A further change during the keep-out restarts the keep-out count. An intermediate code held for fewer than `KEEPOUT_CYC` cycles never appears on `vid_acc`.
- R5: `vid_xient` rises at the third rising edge after a raw change and stays high through the keep-out.
- R6: After a code is accepted, `vid_xient` stays high for exactly `MASK_CYC` more cycles. It falls at the (3 + `KEEPOUT_CYC` + `MASK_CYC`)th rising edge after the last raw change. With no change pending, it stays low.
- R7: A change made while the window is still open restarts the window. The window then ends `MASK_CYC` cycles after the new code is accepted.
- R8: A change that returns to the accepted code before the keep-out ends leaves `vid_acc` unchanged throughout, but the window still runs its full length.
- R9: `pg_mask` and `force_pwm` are both high exactly when `vid_xient` is high.
- R10: With `en` low, `vid_acc` loads the synchronized code with no keep-out, and `vid_xient` is low from the next rising edge. Raising `en` with an unchanged code opens no window.
- R11: A sequence of single-LSB steps, upward and downward, each held longer than the keep-out, appears on `vid_acc` step by step and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Controller enable; low resynchronizes and clears timers |
| vid_raw | input | 7 | Raw VID code from the processor, asynchronous |
| vid_acc | output | 7 | Accepted (settled) VID code |
| vid_xient | output | 1 | Transient window active |
| pg_mask | output | 1 | Power-good fault mask |
| force_pwm | output | 1 | Force multiphase PWM request |

## Verification
The main function is exercised with several input patterns:
- A clean single step pins down the exact acceptance edge and the exact closing edge of the window.
- A short skewed intermediate code followed by the final code shows that a restarted keep-out hides the intermediate value.
- A second change inside an open window separates a retriggered window from one that runs out on its original schedule.
- A change that goes back to the accepted code shows the timer is retriggered while the output stays unchanged.
- A run of LSB steps up and down checks tracking.
- Dropping enable in the middle of a transient checks the direct reload and the clearing of both timers.

// File: rtl/vid_pkg.sv
package vid_pkg;

  typedef enum logic [0:0] {
    KO_IDLE = 1'b0,
    KO_WAIT = 1'b1
  } ko_state_e;

  // True when a settle counter at 'cur' completes its span on this edge.
  function automatic logic limit_hit(int unsigned cur, int unsigned span);
    return (cur + 1) >= span;
  endfunction

  // Next value of a retriggerable down-counter of length 'len'.
  function automatic int unsigned timer_next(logic load, int unsigned cur,
                                             int unsigned len);
    if (load) return len;
    if (cur != 0) return cur - 1;
    return 0;
  endfunction

endpackage

// File: rtl/vid_sync.sv
module vid_sync #(
  parameter int unsigned W      = 7,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  if (STAGES == 0) begin : g_bypass
    assign q = d;
  end else begin : g_chain
    logic [W-1:0] stg [STAGES];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < int'(STAGES); i++) stg[i] <= '0;
      end else begin
        stg[0] <= d;
        for (int i = 1; i < int'(STAGES); i++) stg[i] <= stg[i-1];
      end
    end
    assign q = stg[STAGES-1];
  end

endmodule

// File: rtl/vid_keepout.sv
module vid_keepout
  import vid_pkg::*;
#(
  parameter int unsigned W           = 7,
  parameter int unsigned KEEPOUT_CYC = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] vid_s,
  output logic [W-1:0] vid_acc,
  output logic         chg_evt,
  output logic         accept_evt,
  output logic         busy
);

  localparam int unsigned CW = $clog2(KEEPOUT_CYC + 1);

  logic [W-1:0]  prev_q;
  logic [W-1:0]  acc_q;
  logic [CW-1:0] cnt_q;
  ko_state_e     st_q;

  // Any difference from last cycle's sample is a fresh change.
  assign chg_evt    = en && (vid_s != prev_q);
  assign accept_evt = en && !chg_evt && (st_q == KO_WAIT) &&
                      limit_hit(32'(cnt_q), KEEPOUT_CYC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      acc_q  <= '0;
      cnt_q  <= '0;
      st_q   <= KO_IDLE;
    end else if (!en) begin
      prev_q <= vid_s;
      acc_q  <= vid_s;
      cnt_q  <= '0;
      st_q   <= KO_IDLE;
    end else begin
      prev_q <= vid_s;
      if (chg_evt) begin
        st_q  <= KO_WAIT;
        cnt_q <= '0;
      end else if (accept_evt) begin
        st_q  <= KO_IDLE;
        cnt_q <= '0;
        acc_q <= vid_s;
      end else if (st_q == KO_WAIT) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign vid_acc = acc_q;
  assign busy    = (st_q == KO_WAIT);

endmodule

// File: rtl/vid_mask_timer.sv
module vid_mask_timer
  import vid_pkg::*;
#(
  parameter int unsigned MASK_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic retrig,
  output logic running
);

  localparam int unsigned MW = $clog2(MASK_CYC + 1);

  logic [MW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (!en) cnt_q <= '0;
    else          cnt_q <= MW'(timer_next(retrig, 32'(cnt_q), MASK_CYC));
  end

  assign running = (cnt_q != '0);

endmodule

// File: rtl/vid_deglitch_ctrl.sv
module vid_deglitch_ctrl #(
  parameter int unsigned VID_W       = 7,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned KEEPOUT_CYC = 40,
  parameter int unsigned MASK_CYC    = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [VID_W-1:0] vid_raw,
  output logic [VID_W-1:0] vid_acc,
  output logic             vid_xient,
  output logic             pg_mask,
  output logic             force_pwm
);

  // Named internal events, visible to the bound checker.
  logic [VID_W-1:0] vid_s;
  logic             chg_evt;
  logic             accept_evt;
  logic             ko_busy;
  logic             mask_run;

  vid_sync #(.W(VID_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(vid_raw), .q(vid_s)
  );

  vid_keepout #(.W(VID_W), .KEEPOUT_CYC(KEEPOUT_CYC)) u_ko (
    .clk(clk), .rst_n(rst_n), .en(en), .vid_s(vid_s),
    .vid_acc(vid_acc), .chg_evt(chg_evt), .accept_evt(accept_evt),
    .busy(ko_busy)
  );

  // Restarted by every change and again when the settled code is taken.
  vid_mask_timer #(.MASK_CYC(MASK_CYC)) u_mask (
    .clk(clk), .rst_n(rst_n), .en(en),
    .retrig(chg_evt | accept_evt), .running(mask_run)
  );

  assign vid_xient = ko_busy | mask_run;
  assign pg_mask   = vid_xient;
  assign force_pwm = vid_xient;

endmodule

// File: rtl/vid_deglitch_chk.sv
module vid_deglitch_chk #(
  parameter int unsigned VID_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             chg_evt,
  input logic             accept_evt,
  input logic [VID_W-1:0] vid_acc,
  input logic             xient
);

  // R3: accepted code moves only on an acceptance (or with enable low)
  p_acc_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !accept_evt) |=> $stable(vid_acc));

  // R5: a detected change opens the window on the next edge
  p_chg_opens_r5: assert property (@(posedge clk) disable iff (!rst_n)
    chg_evt |=> xient);

  // R6: acceptance keeps the window open
  p_accept_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> xient);

  // R6: a closed window stays closed without a new change
  p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !xient && !chg_evt) |=> !xient);

  // R10: enable low closes the window
  p_en_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !xient);

endmodule

bind vid_deglitch_ctrl vid_deglitch_chk #(.VID_W(VID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .chg_evt(chg_evt),
  .accept_evt(accept_evt), .vid_acc(vid_acc), .xient(vid_xient)
);

// File: tb/vid_deglitch_ctrl_test.sv
`timescale 1ns/1ps
module vid_deglitch_ctrl_test;

  localparam int K = 40;
  localparam int M = 1000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [6:0] vid_raw = 7'h00;
  logic [6:0] vid_acc;
  logic       vid_xient, pg_mask, force_pwm;

  int checks = 0;
  int fails = 0;
  string cur_req = "R1";
  bit   watch_on = 1'b0;
  int   watch_val = 0;
  bit   watch_seen = 1'b0;

  always #10 clk = ~clk;

  vid_deglitch_ctrl uut (
    .clk(clk), .rst_n(rst_n), .en(en), .vid_raw(vid_raw),
    .vid_acc(vid_acc), .vid_xient(vid_xient),
    .pg_mask(pg_mask), .force_pwm(force_pwm)
  );

  // Behavioural reference: sample queue, stability count, window countdown.
  int sq[$] = '{0, 0};
  int m_last = 0, m_acc = 0, m_stable = 0, m_left = 0;
  bit m_wait = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq = '{0, 0};
      m_last = 0; m_acc = 0; m_stable = 0; m_left = 0; m_wait = 1'b0;
    end else begin
      int s;
      s = sq[$];
      if (!en) begin
        m_acc = s; m_wait = 1'b0; m_stable = 0; m_left = 0;
      end else if (s != m_last) begin
        m_wait = 1'b1; m_stable = 0; m_left = M;
      end else if (m_wait) begin
        m_stable++;
        if (m_stable == K) begin
          m_wait = 1'b0; m_acc = s; m_left = M;
        end
      end else if (m_left > 0) begin
        m_left--;
      end
      m_last = s;
      void'(sq.pop_back());
      sq.push_front(int'(vid_raw));
    end
  end

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Per-cycle comparison against the reference (R9 covered every cycle).
  always @(negedge clk) begin
    if (rst_n) begin
      bit mx;
      mx = m_wait || (m_left > 0);
      check(cur_req, int'(vid_acc), m_acc & 7'h7f, "vid_acc vs model");
      check(cur_req, int'(vid_xient), int'(mx), "vid_xient vs model");
      check("R9", int'(pg_mask), int'(vid_xient), "pg_mask follows window");
      check("R9", int'(force_pwm), int'(vid_xient), "force_pwm follows window");
      if (watch_on && int'(vid_acc) == watch_val) watch_seen = 1'b1;
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  task automatic wait_neg(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic step_to(int v);
    @(negedge clk);
    #2 vid_raw = 7'(v);
  endtask

  task automatic settle();
    wait_neg(K + M + 10);
  endtask

  initial begin
    // R1: reset state
    wait_neg(3);
    check("R1", int'(vid_acc), 0, "acc in reset");
    check("R1", int'(vid_xient), 0, "window in reset");
    check("R1", int'(pg_mask | force_pwm), 0, "flags in reset");
    #2 rst_n = 1'b1;

    // R2: en low, three-edge latency, no window
    cur_req = "R2";
    step_to(8'h15);
    wait_neg(2);
    check("R2", int'(vid_acc), 0, "acc before third edge");
    wait_neg(1);
    check("R2", int'(vid_acc), 'h15, "acc at third edge");
    check("R10", int'(vid_xient), 0, "no window with en low");

    // R10: enable rising with unchanged code opens nothing
    cur_req = "R10";
    @(negedge clk); #2 en = 1'b1;
    wait_neg(5);
    check("R10", int'(vid_xient), 0, "no window on enable");

    // R3, R5, R6: single step
    cur_req = "R3";
    step_to('h16);
    wait_neg(2);
    check("R5", int'(vid_xient), 0, "window before detection");
    wait_neg(1);
    check("R5", int'(vid_xient), 1, "window at third edge");
    wait_neg(K - 1);
    check("R3", int'(vid_acc), 'h15, "acc held during keep-out");
    wait_neg(1);
    check("R3", int'(vid_acc), 'h16, "acc at acceptance edge");
    cur_req = "R6";
    wait_neg(M - 1);
    check("R6", int'(vid_xient), 1, "window on last masked cycle");
    wait_neg(1);
    check("R6", int'(vid_xient), 0, "window closed after mask");
    wait_neg(5);

    // R4: skewed intermediate code then final code
    cur_req = "R4";
    watch_val = 'h1f; watch_seen = 1'b0; watch_on = 1'b1;
    step_to('h1f);
    wait_neg(4);
    step_to('h17);
    wait_neg(K + 2);
    check("R4", int'(vid_acc), 'h16, "acc held after restart");
    wait_neg(1);
    check("R4", int'(vid_acc), 'h17, "final code accepted");
    check("R4", int'(watch_seen), 0, "intermediate code never shown");
    watch_on = 1'b0;

    // R7: change inside an open window restarts it
    cur_req = "R7";
    wait_neg(200);
    step_to('h18);
    wait_neg(K + 3);
    check("R7", int'(vid_acc), 'h18, "retriggered code accepted");
    wait_neg(M - 1);
    check("R7", int'(vid_xient), 1, "window extended");
    wait_neg(1);
    check("R7", int'(vid_xient), 0, "extended window closes");
    wait_neg(5);

    // R8: return to the accepted code inside the keep-out
    cur_req = "R8";
    watch_val = 'h19; watch_seen = 1'b0; watch_on = 1'b1;
    step_to('h19);
    wait_neg(10);
    step_to('h18);
    wait_neg(K + 3 + M - 1);
    check("R8", int'(vid_acc), 'h18, "acc unchanged");
    check("R8", int'(vid_xient), 1, "window still full length");
    wait_neg(1);
    check("R8", int'(vid_xient), 0, "window ends");
    check("R8", int'(watch_seen), 0, "departed code never shown");
    watch_on = 1'b0;

    // R11: LSB steps up then down
    cur_req = "R11";
    for (int v = 'h19; v <= 'h1c; v++) begin
      step_to(v);
      wait_neg(K + 3);
      check("R11", int'(vid_acc), v, "upward step tracked");
      wait_neg(7);
    end
    for (int v = 'h1b; v >= 'h1a; v--) begin
      step_to(v);
      wait_neg(K + 3);
      check("R11", int'(vid_acc), v, "downward step tracked");
      wait_neg(7);
    end
    settle();

    // R10: enable drop mid-transient
    cur_req = "R10";
    step_to('h30);
    wait_neg(10);
    check("R10", int'(vid_xient), 1, "window open before drop");
    #2 en = 1'b0;
    wait_neg(1);
    check("R10", int'(vid_xient), 0, "window cleared by enable low");
    check("R10", int'(vid_acc), 'h30, "direct reload with enable low");
    #2 en = 1'b1;
    wait_neg(5);
    check("R10", int'(vid_xient), 0, "no window after re-enable");

    summary();
  end

endmodule